// File: doc/BRIEF.md
# Power Clamp Ramp Sequencer

This block produces the 8-bit control word for the power switch of a single processor core. The word reads 0xFF when the switch is fully closed and 0x00 when it is fully open. An open request does not jump straight to 0x00. The word passes through a fixed sequence of intermediate values, so that the inrush current into the core's supply stays limited. A close request gates the core off in one step.

Each value written to the switch is held for a fixed number of microsecond tick pulses before the next step. The dwell is counted in ticks and not in clock cycles, so its length does not change with the clock frequency. A busy flag covers the whole of a sequence. A one-cycle done pulse marks the end of every sequence, including an open request that finds the switch already open and so needs no ramp.

Top module: `pwr_clamp_ramp`

## Requirements
- R1: After reset, `sw_word` is 0xFF (switch closed), `busy` is 0 and `done` is 0.
- R2: An accepted open request starting from 0xFF drives `sw_word` through 0xFF, 0xFE, 0xF8, 0xF0 and 0x00, in that order. After 0xFF the word therefore changes exactly four times, and it ends at 0x00.
- R3: Each value of a ramp is held for exactly `DWELL_TICKS` cycles with `us_tick` high. An open ramp spans 5×`DWELL_TICKS` ticks while `busy` is high. The word changes only on a cycle with `us_tick` high.
- R4: An accepted close request sets `sw_word` to 0xFF, then waits `DWELL_TICKS` ticks before it signals done.
- R5: An open request while idle with `sw_word` already at 0x00 raises `done` on the next cycle. `busy` is not raised and the word is not changed.
- R6: While `busy` is high, `open_req` and `close_req` are ignored, and the running sequence ends with its own final word.
- R7: If `open_req` and `close_req` are both high in the same idle cycle, the close request is taken.
- R8: `done` is high for exactly one cycle per sequence. `busy` is low whenever `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| open_req | input | 1 | Request to ramp the switch open |
| close_req | input | 1 | Request to close the switch; takes precedence |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| sw_word | output | 8 | Switch control word, 0xFF closed, 0x00 open |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The sequencer is driven with open, close and simultaneous requests. These start from both the closed and the open state, so a full five-step ramp, a single-step close and an immediate no-ramp completion can each be told apart by the number of word changes and the tick count. The recorded word changes of an open ramp are compared value by value with the fixed step sequence. This separates a wrong step order from a wrong step count. Requests pulsed in the middle of a ramp and a double request from the open state show whether the acceptance gating and the close precedence work.

// File: rtl/pwr_clamp_ramp.sv
module pwr_clamp_ramp #(
  parameter int DWELL_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       open_req,
  input  logic       close_req,
  input  logic       us_tick,
  output logic [7:0] sw_word,
  output logic       busy,
  output logic       done
);
  localparam int         CNT_W     = (DWELL_TICKS > 1) ? $clog2(DWELL_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_TICKS - 1);
  localparam logic [2:0] LAST_STEP = 3'd4;
  localparam logic [7:0] CLOSED    = 8'hFF;
  localparam logic [7:0] OPENED    = 8'h00;

  logic [7:0]       word_q;
  logic             busy_q, done_q, closing_q;
  logic [2:0]       step_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [7:0] step_word(input logic [2:0] s);
    case (s)
      3'd0:    step_word = 8'hFF;
      3'd1:    step_word = 8'hFE;
      3'd2:    step_word = 8'hF8;
      3'd3:    step_word = 8'hF0;
      default: step_word = 8'h00;
    endcase
  endfunction

  wire dwell_end = us_tick && (cnt_q == CNT_LAST);
  wire seq_end   = closing_q || (step_q == LAST_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= CLOSED;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      closing_q <= 1'b0;
      step_q    <= '0;
      cnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (close_req) begin
          word_q    <= CLOSED;
          busy_q    <= 1'b1;
          closing_q <= 1'b1;
          step_q    <= '0;
          cnt_q     <= '0;
        end else if (open_req) begin
          if (word_q == OPENED) begin
            done_q <= 1'b1;
          end else begin
            word_q    <= step_word(3'd0);
            busy_q    <= 1'b1;
            closing_q <= 1'b0;
            step_q    <= '0;
            cnt_q     <= '0;
          end
        end
      end else if (us_tick) begin
        if (dwell_end) begin
          cnt_q <= '0;
          if (seq_end) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + 3'd1;
            word_q <= step_word(step_q + 3'd1);
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign sw_word = word_q;
  assign busy    = busy_q;
  assign done    = done_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R3
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !us_tick) |=> $stable(sw_word));

  // R2
  word_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_word == 8'hFF) || (sw_word == 8'hFE) || (sw_word == 8'hF8) ||
    (sw_word == 8'hF0) || (sw_word == 8'h00));

  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !us_tick) |=> busy);

endmodule

// File: tb/tb_pwr_clamp_ramp.sv
module tb_pwr_clamp_ramp;
  localparam int CLK_P    = 10;
  localparam int DWELL    = 10;
  localparam int TICK_CYC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic open_req = 1'b0, close_req = 1'b0, us_tick = 1'b0;
  logic [7:0] sw_word;
  logic busy, done;

  int checks = 0, errors = 0;

  pwr_clamp_ramp #(.DWELL_TICKS(DWELL)) dut (
    .clk(clk), .rst_n(rst_n), .open_req(open_req), .close_req(close_req),
    .us_tick(us_tick), .sw_word(sw_word), .busy(busy), .done(done));

  always #(CLK_P/2) clk = ~clk;

  int div = 0;
  always @(negedge clk) begin
    div = (div == TICK_CYC - 1) ? 0 : div + 1;
    us_tick = (div == TICK_CYC - 1);
  end

  // monitor
  int tick_cnt = 0, chg_cnt = 0, done_cnt = 0, dbl_done = 0;
  bit busy_seen = 0;
  logic [7:0] chg_log [0:7];
  logic [7:0] prev_word = 8'hFF;
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && us_tick) tick_cnt++;
      if (sw_word != prev_word) begin
        if (chg_cnt < 8) chg_log[chg_cnt] = sw_word;
        chg_cnt++;
      end
      if (done) done_cnt++;
      if (done && prev_done) dbl_done++;
      if (busy) busy_seen = 1;
    end
    prev_word = sw_word;
    prev_done = done;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic issue(input bit o, input bit c);
    @(negedge clk);
    tick_cnt = 0; chg_cnt = 0; done_cnt = 0; busy_seen = 0;
    @(negedge clk);
    open_req = o; close_req = c;
    @(negedge clk);
    open_req = 0; close_req = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && done_cnt == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // fields: [15:14] req {close,open}, [13:11] steps, [10:8] changes, [7:0] final word
  localparam logic [15:0] VEC [0:6] = '{
    {2'b10, 3'd1, 3'd0, 8'hFF},
    {2'b01, 3'd5, 3'd4, 8'h00},
    {2'b01, 3'd0, 3'd0, 8'h00},
    {2'b11, 3'd1, 3'd1, 8'hFF},
    {2'b01, 3'd5, 3'd4, 8'h00},
    {2'b10, 3'd1, 3'd1, 8'hFF},
    {2'b11, 3'd1, 3'd0, 8'hFF}
  };

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 word", sw_word, 8'hFF);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after release", sw_word, 8'hFF);

    for (int v = 0; v < 7; v++) begin
      issue(VEC[v][14], VEC[v][15]);
      wait_done();
      check($sformatf("R3/R4 vec%0d ticks", v), tick_cnt, int'(VEC[v][13:11]) * DWELL);
      check($sformatf("R2 vec%0d changes", v), chg_cnt, int'(VEC[v][10:8]));
      check($sformatf("R2/R7 vec%0d final", v), sw_word, VEC[v][7:0]);
      check($sformatf("R8 vec%0d done count", v), done_cnt, 1);
      check($sformatf("R8 vec%0d busy idle", v), busy, 0);
      if (VEC[v][13:11] == 3'd0)
        check($sformatf("R5 vec%0d no busy", v), busy_seen, 0);
      if (VEC[v][10:8] == 3'd4) begin
        check("R2 step1", chg_log[0], 8'hFE);
        check("R2 step2", chg_log[1], 8'hF8);
        check("R2 step3", chg_log[2], 8'hF0);
        check("R2 step4", chg_log[3], 8'h00);
      end
    end

    // R6: requests during an open ramp are ignored
    issue(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    check("R6 busy mid ramp", busy, 1);
    close_req = 1; @(negedge clk); close_req = 0;
    repeat (40) @(negedge clk);
    open_req = 1; close_req = 1; @(negedge clk); open_req = 0; close_req = 0;
    wait_done();
    check("R6 final open", sw_word, 8'h00);
    check("R6 ticks", tick_cnt, 5 * DWELL);
    check("R6 changes", chg_cnt, 4);
    check("R6 done count", done_cnt, 1);

    // R5: immediate completion timing, done on the cycle after the request
    @(negedge clk);
    done_cnt = 0;
    open_req = 1; @(negedge clk); open_req = 0;
    check("R5 done next cycle", done, 1);
    check("R5 busy stays low", busy, 0);
    @(negedge clk);
    check("R8 done single cycle", done, 0);
    check("R5 word unchanged", sw_word, 8'h00);

    check("R8 no double done", dbl_done, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule